// File: doc/BRIEF.md
# Three-Wire SPI Accelerometer Poller

This block is an SPI master that runs a three-axis accelerometer over a three-wire link. A single bidirectional data line carries the master's command bits and the device's reply bits. After reset the block writes two setup registers. The first selects a 10-bit, right-justified, ±2 g data format. The second selects a 400 Hz output data rate. The block then loops for as long as it runs. In each pass it reads the interrupt-source register until the data-ready flag is set. It then fetches all six axis bytes in one multi-byte read, so the X, Y and Z values always belong to the same sample.

The serial clock comes from a divider of the system clock. It idles high, the master changes data on falling edges, and both sides sample on rising edges. On a read, the master stops driving the data line once the eighth command bit has been sent. Each axis is built from its low and high bytes. The 10-bit two's-complement value is sign-extended to 16 bits and presented together with a one-cycle valid strobe.

Top module: `acc3w_poller`

## Requirements
- R1: The serial clock `sclk` is high whenever `cs_n` is high, and it also starts and ends every frame high.
- R2: While `cs_n` is low, the master changes `sdio_o` only in the cycle in which `sclk` falls. The device samples on rising edges, and so does the master for the bits it reads.
- R3: The first byte of each frame is sent MSB first. Its bit 7 is 1 for a read and 0 for a write, bit 6 is 1 for a multi-byte transfer, and bits 5:0 hold the register address.
- R4: After reset, the first frame is a two-byte write of 0x00 to address 0x31 (data format). The second frame is a two-byte write of 0x0C to address 0x2C (400 Hz rate).
- R5: In a read frame, `sdio_oe` goes low at the rising edge of the eighth command bit. It stays low until `cs_n` rises.
- R6: A poll is a single-byte read of address 0x30. If bit 7 of the reply is 1, a burst read follows. If it is 0, another poll follows. All other reply bits are ignored.
- R7: The burst is one multi-byte read of six bytes starting at address 0x32. The bytes arrive in this order: X low, X high, Y low, Y high, Z low, Z high.
- R8: Each axis value is {high byte, low byte}. Bits 9:0 are taken as a two's-complement number and sign-extended to 16 bits on `x_out`, `y_out` and `z_out`.
- R9: `sample_valid` is high for exactly one clock per completed burst. After that pulse the axis outputs hold their values until the next burst completes.
- R10: An `sclk` half period lasts HALF_DIV system clocks. Between two frames, `cs_n` stays high for at least 2*HALF_DIV clocks.
- R11: During reset and just after it: `cs_n`=1, `sclk`=1, `sdio_oe`=0, `sample_valid`=0, and the axis outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| sdio_o | output | 1 | Value the master drives on the data line |
| sdio_oe | output | 1 | High while the master drives the data line |
| sdio_i | input | 1 | Level seen on the data line |
| x_out | output | 16 | Sign-extended X sample |
| y_out | output | 16 | Sign-extended Y sample |
| z_out | output | 16 | Sign-extended Z sample |
| sample_valid | output | 1 | One-cycle strobe for a new XYZ set |

## Verification
The assertions check the line-level rules on every cycle. These are the idle level of the serial clock, data changing only on falling edges, release of the data line during the reply phase of a read, the chip-select gap, the single-cycle valid pulse, and the return to polling when the ready bit is clear. The bench's scenarios are needed for everything that depends on content. That covers the setup sequence and its values, the command-byte encoding, the number of polls for each sample, the byte order of the burst, and the sign extension across a sweep of axis values. A bench device model on the shared line drives all of these.

// File: rtl/acc3w_pkg.sv
package acc3w_pkg;

    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SAMPLE_W  = 16;
    localparam int unsigned NAXES     = 3;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_BITS,
        SH_TRAIL,
        SH_GAP
    } sh_state_e;

    typedef enum logic [3:0] {
        SQ_FMT,
        SQ_FMT_W,
        SQ_RATE,
        SQ_RATE_W,
        SQ_POLL,
        SQ_POLL_W,
        SQ_BURST,
        SQ_BURST_W
    } sq_state_e;

    typedef struct packed {
        logic              rd;
        logic              multi;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [2:0]        nbytes;
    } xfer_req_t;

    function automatic logic [BYTE_W-1:0] cmd_byte(xfer_req_t r);
        return {r.rd, r.multi, r.addr};
    endfunction

    function automatic logic [SAMPLE_W-1:0] sext_sample(logic [SAMPLE_W-1:0] raw,
                                                        int unsigned bits);
        logic [SAMPLE_W-1:0] t;
        t = raw << (SAMPLE_W - bits);
        return SAMPLE_W'($signed(t) >>> (SAMPLE_W - bits));
    endfunction

endpackage

// File: rtl/acc3w_shifter.sv
module acc3w_shifter
    import acc3w_pkg::*;
#(
    parameter int unsigned HALF_DIV  = 4,
    parameter int unsigned MAX_BYTES = 6,
    localparam int unsigned RX_W     = BYTE_W * MAX_BYTES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  xfer_req_t       req,
    output logic            done,
    output logic [RX_W-1:0] rx_data,
    output logic            sclk,
    output logic            cs_n,
    output logic            sdio_o,
    output logic            sdio_oe,
    input  logic            sdio_i
);
    localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
    localparam int unsigned BIT_W = $clog2(BYTE_W * (MAX_BYTES + 1) + 1);
    localparam int unsigned TX_W  = 2 * BYTE_W;

    sh_state_e        state;
    logic [CNT_W-1:0] hcnt;
    logic             tick;
    logic [TX_W-1:0]  tx;
    logic [BIT_W-1:0] bit_idx;
    logic [BIT_W-1:0] total;
    logic             is_rd;
    logic             gap_half;

    assign tick = (hcnt == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || state == SH_IDLE || tick) hcnt <= '0;
        else                                 hcnt <= hcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            sclk     <= 1'b1;
            cs_n     <= 1'b1;
            sdio_o   <= 1'b0;
            sdio_oe  <= 1'b0;
            tx       <= '0;
            rx_data  <= '0;
            bit_idx  <= '0;
            total    <= '0;
            is_rd    <= 1'b0;
            gap_half <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        cs_n    <= 1'b0;
                        sdio_oe <= 1'b1;
                        tx      <= {cmd_byte(req), req.rd ? '0 : req.wdata};
                        is_rd   <= req.rd;
                        total   <= BIT_W'({req.nbytes, 3'b000}) + BIT_W'(BYTE_W);
                        rx_data <= '0;
                        bit_idx <= '0;
                        state   <= SH_LEAD;
                    end
                end
                SH_LEAD: begin
                    if (tick) begin
                        sclk   <= 1'b0;
                        sdio_o <= tx[TX_W-1];
                        tx     <= tx << 1;
                        state  <= SH_BITS;
                    end
                end
                SH_BITS: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                            if (bit_idx >= BIT_W'(BYTE_W))
                                rx_data <= {rx_data[RX_W-2:0], sdio_i};
                            if (is_rd && bit_idx == BIT_W'(BYTE_W - 1))
                                sdio_oe <= 1'b0;
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == total - 1'b1)
                                state <= SH_TRAIL;
                        end else begin
                            sclk   <= 1'b0;
                            sdio_o <= tx[TX_W-1];
                            tx     <= tx << 1;
                        end
                    end
                end
                SH_TRAIL: begin
                    if (tick) begin
                        cs_n     <= 1'b1;
                        sdio_oe  <= 1'b0;
                        gap_half <= 1'b0;
                        state    <= SH_GAP;
                    end
                end
                SH_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= SH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R1: clock parks high outside a frame
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R2: master data changes only together with a falling clock
    p_drive_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(sdio_o));

    // R5: line released for the reply phase of a read
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && is_rd && bit_idx >= BIT_W'(BYTE_W)) |-> !sdio_oe);

    // R10: deselect lasts beyond a single cycle
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/acc3w_sequencer.sv
module acc3w_sequencer
    import acc3w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FMT_ADDR    = 6'h31,
    parameter logic [BYTE_W-1:0] FMT_VAL     = 8'h00,
    parameter logic [ADDR_W-1:0] RATE_ADDR   = 6'h2C,
    parameter logic [BYTE_W-1:0] RATE_VAL    = 8'h0C,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h30,
    parameter int unsigned       READY_BIT   = 7,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 6'h32,
    parameter int unsigned       MAX_BYTES   = 6,
    localparam int unsigned      RX_W        = BYTE_W * MAX_BYTES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done,
    input  logic [RX_W-1:0] rx_data,
    output logic            start,
    output xfer_req_t       req,
    output logic            burst_done
);
    localparam int unsigned BURST_BYTES = 2 * NAXES;

    sq_state_e state;

    function automatic xfer_req_t mk_req(logic rd, logic multi,
                                         logic [ADDR_W-1:0] a,
                                         logic [BYTE_W-1:0] d,
                                         int unsigned n);
        xfer_req_t r;
        r.rd     = rd;
        r.multi  = multi;
        r.addr   = a;
        r.wdata  = d;
        r.nbytes = 3'(n);
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_FMT;
            start      <= 1'b0;
            req        <= '0;
            burst_done <= 1'b0;
        end else begin
            start      <= 1'b0;
            burst_done <= 1'b0;
            case (state)
                SQ_FMT: begin
                    req   <= mk_req(1'b0, 1'b0, FMT_ADDR, FMT_VAL, 1);
                    start <= 1'b1;
                    state <= SQ_FMT_W;
                end
                SQ_FMT_W:  if (done) state <= SQ_RATE;
                SQ_RATE: begin
                    req   <= mk_req(1'b0, 1'b0, RATE_ADDR, RATE_VAL, 1);
                    start <= 1'b1;
                    state <= SQ_RATE_W;
                end
                SQ_RATE_W: if (done) state <= SQ_POLL;
                SQ_POLL: begin
                    req   <= mk_req(1'b1, 1'b0, STATUS_ADDR, '0, 1);
                    start <= 1'b1;
                    state <= SQ_POLL_W;
                end
                SQ_POLL_W: begin
                    if (done) state <= rx_data[READY_BIT] ? SQ_BURST : SQ_POLL;
                end
                SQ_BURST: begin
                    req   <= mk_req(1'b1, 1'b1, DATA_ADDR, '0, BURST_BYTES);
                    start <= 1'b1;
                    state <= SQ_BURST_W;
                end
                SQ_BURST_W: begin
                    if (done) begin
                        burst_done <= 1'b1;
                        state      <= SQ_POLL;
                    end
                end
                default: state <= SQ_FMT;
            endcase
        end
    end

    // R6: a clear ready flag leads straight back to polling
    p_repoll_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_POLL_W && done && !rx_data[READY_BIT]) |=> state == SQ_POLL);

    // R6: a burst is only requested after a ready poll result
    p_burst_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_BURST) |-> $past(state == SQ_POLL_W && done));

endmodule

// File: rtl/acc3w_unpack.sv
module acc3w_unpack
    import acc3w_pkg::*;
#(
    parameter int unsigned  SAMPLE_BITS = 10,
    parameter int unsigned  MAX_BYTES   = 6,
    localparam int unsigned RX_W        = BYTE_W * MAX_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [RX_W-1:0]     bytes,
    output logic [SAMPLE_W-1:0] axis_out [NAXES],
    output logic                valid
);
    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        localparam int unsigned LO_TOP = RX_W - 1 - 2 * BYTE_W * a;
        localparam int unsigned HI_TOP = LO_TOP - BYTE_W;
        logic [SAMPLE_W-1:0] raw;
        assign raw = {bytes[HI_TOP -: BYTE_W], bytes[LO_TOP -: BYTE_W]};

        always_ff @(posedge clk) begin
            if (rst)       axis_out[a] <= '0;
            else if (load) axis_out[a] <= sext_sample(raw, SAMPLE_BITS);
        end

        // R9: outputs stay put between completed bursts
        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !$past(load) |-> $stable(axis_out[a]));
    end

    always_ff @(posedge clk) begin
        if (rst) valid <= 1'b0;
        else     valid <= load;
    end

    // R9: valid strobe is a single cycle
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/acc3w_poller.sv
module acc3w_poller
    import acc3w_pkg::*;
#(
    parameter int unsigned       HALF_DIV    = 4,
    parameter int unsigned       SAMPLE_BITS = 10,
    parameter logic [ADDR_W-1:0] FMT_ADDR    = 6'h31,
    parameter logic [BYTE_W-1:0] FMT_VAL     = 8'h00,
    parameter logic [ADDR_W-1:0] RATE_ADDR   = 6'h2C,
    parameter logic [BYTE_W-1:0] RATE_VAL    = 8'h0C,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h30,
    parameter int unsigned       READY_BIT   = 7,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 6'h32
) (
    input  logic        clk,
    input  logic        rst,
    output logic        sclk,
    output logic        cs_n,
    output logic        sdio_o,
    output logic        sdio_oe,
    input  logic        sdio_i,
    output logic [15:0] x_out,
    output logic [15:0] y_out,
    output logic [15:0] z_out,
    output logic        sample_valid
);
    localparam int unsigned MAX_BYTES = 2 * NAXES;
    localparam int unsigned RX_W      = BYTE_W * MAX_BYTES;

    logic            start;
    logic            done;
    logic            burst_done;
    xfer_req_t       req;
    logic [RX_W-1:0] rx_data;
    logic [SAMPLE_W-1:0] axes [NAXES];

    acc3w_shifter #(.HALF_DIV(HALF_DIV), .MAX_BYTES(MAX_BYTES)) u_shift (
        .clk(clk), .rst(rst), .start(start), .req(req), .done(done),
        .rx_data(rx_data), .sclk(sclk), .cs_n(cs_n), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    acc3w_sequencer #(
        .FMT_ADDR(FMT_ADDR), .FMT_VAL(FMT_VAL), .RATE_ADDR(RATE_ADDR),
        .RATE_VAL(RATE_VAL), .STATUS_ADDR(STATUS_ADDR), .READY_BIT(READY_BIT),
        .DATA_ADDR(DATA_ADDR), .MAX_BYTES(MAX_BYTES)
    ) u_seq (
        .clk(clk), .rst(rst), .done(done), .rx_data(rx_data),
        .start(start), .req(req), .burst_done(burst_done)
    );

    acc3w_unpack #(.SAMPLE_BITS(SAMPLE_BITS), .MAX_BYTES(MAX_BYTES)) u_unpack (
        .clk(clk), .rst(rst), .load(burst_done), .bytes(rx_data),
        .axis_out(axes), .valid(sample_valid)
    );

    assign x_out = axes[0];
    assign y_out = axes[1];
    assign z_out = axes[2];

endmodule

// File: tb/tb_acc3w_poller.sv
module tb_acc3w_poller;
    localparam int HALF = 2;
    localparam int NSAMP = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk, cs_n, sdio_o, sdio_oe, sdio_i;
    logic [15:0] x_out, y_out, z_out;
    logic sample_valid;
    logic slv_out = 1'b0;

    always #2 clk = ~clk;

    assign sdio_i = sdio_oe ? sdio_o : slv_out;

    acc3w_poller #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .sdio_i(sdio_i), .x_out(x_out), .y_out(y_out),
        .z_out(z_out), .sample_valid(sample_valid)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // device model state
    logic [15:0] cur_ax [3];
    int   pend_nr = 0;
    int   polls = 0;
    int   frames = 0;
    int   sbit = 0;
    logic [7:0] cmd = '0;
    logic [7:0] wbyte = '0;
    bit   oe_bad = 0;
    int   hi_cnt = 0;
    logic [7:0] status_val = '0;

    function automatic logic [7:0] reg_val(input int a);
        if (a == 'h30) return status_val;
        if (a >= 'h32 && a <= 'h37) begin
            automatic int k = a - 'h32;
            return (k % 2 == 0) ? cur_ax[k/2][7:0] : cur_ax[k/2][15:8];
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (cs_n) hi_cnt <= hi_cnt + 1;
        else      hi_cnt <= 0;
    end

    always @(negedge cs_n) begin
        sbit = 0; oe_bad = 0;
        check(sclk == 1'b1, "R1 sclk at select", sclk, 1);
        if (frames > 0)
            check(hi_cnt >= 2*HALF, "R10 deselect gap", hi_cnt, 2*HALF);
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (sbit < 8) cmd = {cmd[6:0], sdio_o};
            else if (!cmd[7]) wbyte = {wbyte[6:0], sdio_o};
            else if (sdio_oe) oe_bad = 1;
            sbit++;
            if (sbit == 8 && cmd[7] && cmd[5:0] == 6'h30) begin
                polls++;
                if (pend_nr > 0) begin status_val = 8'h03; pend_nr--; end
                else status_val = 8'h83;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && sbit >= 8 && cmd[7]) begin
            automatic int off = sbit - 8;
            automatic int a = cmd[6] ? cmd[5:0] + off/8 : cmd[5:0];
            automatic logic [7:0] b = reg_val(a);
            slv_out <= b[7 - off%8];
        end
    end

    always @(posedge cs_n) begin
        if (!rst) begin
            frames++;
            if (frames == 1) begin
                check(cmd == 8'h31 && sbit == 16, "R4 format write cmd (R3/R2)", {cmd, 8'(sbit)}, 16'h3110);
                check(wbyte == 8'h00, "R4 format value", wbyte, 8'h00);
            end else if (frames == 2) begin
                check(cmd == 8'h2C && sbit == 16, "R4 rate write cmd", {cmd, 8'(sbit)}, 16'h2C10);
                check(wbyte == 8'h0C, "R4 rate value", wbyte, 8'h0C);
            end else if (cmd[5:0] == 6'h30) begin
                check(cmd == 8'hB0 && sbit == 16, "R6 poll frame R3", {cmd, 8'(sbit)}, 16'hB010);
            end else begin
                check(cmd == 8'hF2 && sbit == 56, "R7 burst frame R3", {cmd, 8'(sbit)}, 16'hF238);
            end
            if (cmd[7]) check(!oe_bad, "R5 release during reply", oe_bad, 0);
        end
    end

    function automatic logic [15:0] dev_word(input int v);
        logic [9:0] t = 10'(v);
        return {{6{t[9]}}, t};
    endfunction

    int vals [3];

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 3; a++) cur_ax[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cs_n && sclk && !sdio_oe && !sample_valid, "R11 reset outputs",
              {cs_n, sclk, sdio_oe, sample_valid}, 4'b1100);
        check(x_out == 0 && y_out == 0 && z_out == 0, "R11 reset samples", x_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && sclk, "R11 idle after reset", {cs_n, sclk}, 2'b11);
        for (int k = 0; k < NSAMP; k++) begin
            case (k)
                0: vals[0] = 'h200;
                1: vals[0] = 'h1FF;
                2: vals[0] = 'h3FF;
                3: vals[0] = 0;
                default: vals[0] = (k*97 + 512) % 1024;
            endcase
            vals[1] = (k*331 + 3) % 1024;
            vals[2] = (1023 - k*43) % 1024;
            if (vals[2] < 0) vals[2] += 1024;
            for (int a = 0; a < 3; a++) cur_ax[a] = dev_word(vals[a]);
            pend_nr = k % 4;
            polls = 0;
            while (!sample_valid) @(negedge clk);
            check(polls == (k % 4) + 1, "R6 poll count", polls, (k % 4) + 1);
            for (int a = 0; a < 3; a++) begin
                automatic int e = (vals[a] >= 512) ? (vals[a] - 1024) & 16'hFFFF : vals[a];
                automatic logic [15:0] got = (a == 0) ? x_out : (a == 1) ? y_out : z_out;
                check(got == 16'(e), "R8 axis value R7", got, e);
            end
            @(negedge clk);
            check(!sample_valid, "R9 single-cycle valid", sample_valid, 0);
            repeat (5) @(negedge clk);
            check(x_out == 16'(dev_word(vals[0])), "R9 hold", x_out, dev_word(vals[0]));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule